// File: doc/BRIEF.md
# Command-Byte Register Slave on a Two-Wire Serial Bus

This block is the serial-bus front end of a light-sensing device. It watches the clock and data lines of an SMBus/I2C bus that it oversamples with the system clock. It detects START and STOP conditions and matches a fixed 7-bit device address. While it is addressed, it acknowledges every byte the master writes. The data line is driven open-drain: the block has no push-pull data output, only an enable that pulls the line low.

A byte that the master writes with its top bit set is a command byte. Its lowest four bits choose one of sixteen register slots, and that choice holds for every later byte in this transaction and in the transactions that follow. A written byte with its top bit clear is data, and it goes to the chosen slot. Reads return the chosen slot. The slot number does not advance after an access. This allows Send Byte (command only), Write Byte (command then data), Receive Byte (read of the current slot) and Read Byte (command, repeated START, read). Two 16-bit channel results are presented as four read-only byte slots. A 2-bit power field in slot 0 drives an output pin.

Top module: `i2cs_cmd_slave`

## Requirements
- R1: After reset, sda_oe_o is 0, power_o is 0, slot 0 is the selected slot, and every writable slot holds 0x00.
- R2: The block acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 0x39). For any other address it does not pull SDA low during that ACK clock, and it stays silent until the next START.
- R3: A written byte with bit 7 = 1 sets the selected slot to its bits 3:0 and is not stored into any slot.
- R4: A written byte with bit 7 = 0 is stored into the selected slot. Several data bytes in one transaction all go to that same slot, and the last one remains.
- R5: The selected slot persists across STOP and START. A Receive Byte returns the slot chosen by an earlier transaction.
- R6: Slot 0 keeps only bits 1:0 of a written byte and reads back as 0b000000pp. power_o equals those two bits and changes only on a write to slot 0.
- R7: Slots 7, 8 and 9 read 0x00. Slots 12 to 15 read ch0[7:0], ch0[15:8], ch1[7:0] and ch1[15:8]. Writes to any of these slots leave what they read unchanged.
- R8: Read data is sent MSB first. SDA changes only after an SCL falling edge. When the master ACKs, the same slot is sent again. When the master NACKs, the block releases SDA.
- R9: A START in the middle of a byte abandons that byte (nothing is stored) and restarts address matching.
- R10: After a STOP the block releases SDA and ignores bus traffic until the next START.
- R11: The block pulls SDA low during the ACK clock of every byte written after its own address, whether the byte is a command or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| ch0_data_i | input | 16 | First channel result |
| ch1_data_i | input | 16 | Second channel result |
| power_o | output | 2 | Power field held in slot 0 |

## Verification
Some rules are checked on every cycle. SDA is released one cycle after any STOP. Any START puts the block back into address matching with SDA released. The pull-down only turns on right after an SCL falling edge. power_o moves only when slot 0 is written. Reserved slots always read zero. Other behaviour needs whole transactions and is shown only by the bench scenarios. These scenarios cover the persistence of the selected slot between transactions, the absence of auto-increment, a command byte that is not stored as data, an abandoned byte after a repeated START, silence after a foreign address, and the values returned from the channel slots.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ADDR_W   = 4;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int BYTE_W   = 8;

    // Slot map; slot 0 feeds the power output, 12..15 mirror channel results
    localparam logic [ADDR_W-1:0] SLOT_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] SLOT_RSV_A = 4'h7;
    localparam logic [ADDR_W-1:0] SLOT_RSV_B = 4'h9;
    localparam logic [ADDR_W-1:0] SLOT_C0_LO = 4'hC;
    localparam logic [ADDR_W-1:0] SLOT_C0_HI = 4'hD;
    localparam logic [ADDR_W-1:0] SLOT_C1_LO = 4'hE;
    localparam logic [ADDR_W-1:0] SLOT_C1_HI = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_WR,
        ST_ACK_W,
        ST_RD,
        ST_RD_ACK
    } bus_st_e;

    typedef struct packed {
        bus_st_e             st;
        logic [2:0]          bitcnt;
        logic                byte_done;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   tx;
        logic                rw;
        logic                mack;
        logic [ADDR_W-1:0]   sel;
        logic                oe;
        logic                wr_en;
        logic [BYTE_W-1:0]   wr_data;
    } fsm_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_i;
                    sda_ff[g] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_ff[g-1];
                    sda_ff[g] <= sda_ff[g-1];
                end
            end
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       ch0_data,
    input  logic [15:0]       ch1_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [1:0]        power
);
    logic [NUM_REGS*BYTE_W-1:0] cells_flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        localparam bit IS_RSV = (g >= int'(SLOT_RSV_A)) && (g <= int'(SLOT_RSV_B));
        localparam bit IS_CH  = (g >= int'(SLOT_C0_LO));
        if (IS_RSV || IS_CH) begin : g_const
            assign cells_flat[g*BYTE_W +: BYTE_W] = '0;
        end else if (g == int'(SLOT_CTRL)) begin : g_ctrl
            logic [1:0] pwr_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pwr_q <= '0;
                else if (wr_en && wr_addr == SLOT_CTRL)
                    pwr_q <= wr_data[1:0];
            end
            assign cells_flat[g*BYTE_W +: BYTE_W] = {{(BYTE_W-2){1'b0}}, pwr_q};
        end else begin : g_store
            logic [BYTE_W-1:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cell_q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g))
                    cell_q <= wr_data;
            end
            assign cells_flat[g*BYTE_W +: BYTE_W] = cell_q;
        end
    end

    always_comb begin
        if (rd_addr == SLOT_C0_LO)      rd_data = ch0_data[7:0];
        else if (rd_addr == SLOT_C0_HI) rd_data = ch0_data[15:8];
        else if (rd_addr == SLOT_C1_LO) rd_data = ch1_data[7:0];
        else if (rd_addr == SLOT_C1_HI) rd_data = ch1_data[15:8];
        else                            rd_data = cells_flat[rd_addr*BYTE_W +: BYTE_W];
    end

    assign power = cells_flat[1:0];

endmodule

// File: rtl/i2cs_cmd_slave.sv
module i2cs_cmd_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h39,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [15:0] ch0_data_i,
    input  logic [15:0] ch1_data_i,
    output logic [1:0]  power_o
);
    logic              sda_s;
    logic              rise_w;
    logic              fall_w;
    logic              start_w;
    logic              stop_w;
    logic [BYTE_W-1:0] rd_data_w;
    fsm_t              q;
    fsm_t              d;

    i2cs_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (rise_w),
        .scl_fall  (fall_w),
        .start_det (start_w),
        .stop_det  (stop_w)
    );

    i2cs_regfile regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (q.wr_en),
        .wr_addr  (q.sel),
        .wr_data  (q.wr_data),
        .rd_addr  (q.sel),
        .ch0_data (ch0_data_i),
        .ch1_data (ch1_data_i),
        .rd_data  (rd_data_w),
        .power    (power_o)
    );

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (start_w) begin
            d.st        = ST_ADDR;
            d.bitcnt    = '0;
            d.byte_done = 1'b0;
            d.oe        = 1'b0;
            d.mack      = 1'b0;
        end else if (stop_w) begin
            d.st        = ST_IDLE;
            d.byte_done = 1'b0;
            d.oe        = 1'b0;
            d.mack      = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WR: begin
                    if (rise_w) begin
                        d.shreg     = {q.shreg[6:0], sda_s};
                        d.bitcnt    = q.bitcnt + 3'd1;
                        d.byte_done = (q.bitcnt == 3'd7);
                    end else if (fall_w && q.byte_done) begin
                        d.byte_done = 1'b0;
                        if (q.st == ST_ADDR) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                d.st = ST_ACK_A;
                                d.rw = q.shreg[0];
                                d.oe = 1'b1;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st = ST_ACK_W;
                            d.oe = 1'b1;
                            if (q.shreg[7]) begin
                                d.sel = q.shreg[ADDR_W-1:0];
                            end else begin
                                d.wr_en   = 1'b1;
                                d.wr_data = q.shreg;
                            end
                        end
                    end
                end
                ST_ACK_A: begin
                    if (fall_w) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.tx = rd_data_w;
                            d.oe = ~rd_data_w[7];
                        end else begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_ACK_W: begin
                    if (fall_w) begin
                        d.st     = ST_WR;
                        d.bitcnt = '0;
                        d.oe     = 1'b0;
                    end
                end
                ST_RD: begin
                    if (rise_w) begin
                        d.bitcnt    = q.bitcnt + 3'd1;
                        d.byte_done = (q.bitcnt == 3'd7);
                    end else if (fall_w) begin
                        if (q.byte_done) begin
                            d.byte_done = 1'b0;
                            d.oe        = 1'b0;
                            d.st        = ST_RD_ACK;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b0};
                            d.oe = ~q.tx[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (rise_w) begin
                        if (sda_s) d.st = ST_IDLE;
                        else       d.mack = 1'b1;
                    end else if (fall_w && q.mack) begin
                        d.mack   = 1'b0;
                        d.st     = ST_RD;
                        d.bitcnt = '0;
                        d.tx     = rd_data_w;
                        d.oe     = ~rd_data_w[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.bitcnt    <= '0;
            q.byte_done <= 1'b0;
            q.shreg     <= '0;
            q.tx        <= '0;
            q.rw        <= 1'b0;
            q.mack      <= 1'b0;
            q.sel       <= SLOT_CTRL;
            q.oe        <= 1'b0;
            q.wr_en     <= 1'b0;
            q.wr_data   <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

endmodule

// File: rtl/i2cs_cmd_slave_chk.sv
module i2cs_cmd_slave_chk
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_det,
    input logic              stop_det,
    input logic              scl_fall,
    input logic              sda_oe,
    input bus_st_e           st,
    input logic              wr_en,
    input logic [ADDR_W-1:0] slot,
    input logic [BYTE_W-1:0] rd_data,
    input logic [1:0]        power
);
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R9
    start_rematch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR) && !sda_oe);

    // R8
    drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R6
    power_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && slot == SLOT_CTRL) |=> $stable(power));

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot >= SLOT_RSV_A && slot <= SLOT_RSV_B) |-> rd_data == '0);

endmodule

bind i2cs_cmd_slave i2cs_cmd_slave_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_w),
    .stop_det  (stop_w),
    .scl_fall  (fall_w),
    .sda_oe    (sda_oe_o),
    .st        (q.st),
    .wr_en     (q.wr_en),
    .slot      (q.sel),
    .rd_data   (rd_data_w),
    .power     (power_o)
);

// File: tb/i2cs_cmd_slave_tb_top.sv
module i2cs_cmd_slave_tb_top;
    localparam int         Q   = 50;
    localparam logic [6:0] DEV = 7'h39;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [15:0] ch0 = 16'hBEEF;
    logic [15:0] ch1 = 16'h1234;
    logic [1:0]  power;
    wire         sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2cs_cmd_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .ch0_data_i (ch0),
        .ch1_data_i (ch1),
        .power_o    (power)
    );

    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    logic [7:0] model [16];
    logic [3:0] sel_m  = 4'h0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        if (a >= 4'h7 && a <= 4'h9) return 8'h00;
        if (a == 4'hC) return ch0[7:0];
        if (a == 4'hD) return ch0[15:8];
        if (a == 4'hE) return ch1[7:0];
        if (a == 4'hF) return ch1[15:8];
        return model[a];
    endfunction

    function automatic bit writable(input logic [3:0] a);
        return !((a >= 4'h7 && a <= 4'h9) || a >= 4'hC);
    endfunction

    function automatic void model_wr(input logic [3:0] a, input logic [7:0] v);
        if (writable(a)) model[a] = (a == 4'h0) ? (v & 8'h03) : v;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_line; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(r);
        ack = ~r;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [6:0] v);
        logic ack;
        bus_start();
        put_byte({DEV, 1'b0}, ack); chk("R2", "addr ack", ack, 1);
        put_byte({4'h8, a}, ack);   chk("R11", "cmd ack", ack, 1);
        put_byte({1'b0, v}, ack);   chk("R11", "data ack", ack, 1);
        bus_stop();
        sel_m = a;
        model_wr(a, {1'b0, v});
        chk("R10", "release after stop", sda_oe, 0);
        chk("R6", "power_o", power, model[0][1:0]);
    endtask

    task automatic do_send(input logic [3:0] a);
        logic ack;
        bus_start();
        put_byte({DEV, 1'b0}, ack); chk("R2", "addr ack", ack, 1);
        put_byte({4'h8, a}, ack);   chk("R3", "cmd ack", ack, 1);
        bus_stop();
        sel_m = a;
    endtask

    task automatic do_read(input logic [3:0] a);
        logic ack;
        logic [7:0] v;
        bus_start();
        put_byte({DEV, 1'b0}, ack); chk("R2", "addr ack", ack, 1);
        put_byte({4'h8, a}, ack);   chk("R3", "cmd ack", ack, 1);
        bus_start();
        put_byte({DEV, 1'b1}, ack); chk("R2", "read addr ack", ack, 1);
        get_byte(1'b0, v);
        bus_stop();
        sel_m = a;
        chk("R7", "read byte", v, exp_rd(a));
        chk("R8", "released after nack", sda_oe, 0);
    endtask

    task automatic do_receive();
        logic ack;
        logic [7:0] v;
        bus_start();
        put_byte({DEV, 1'b1}, ack); chk("R2", "addr ack", ack, 1);
        get_byte(1'b0, v);
        bus_stop();
        chk("R5", "receive byte", v, exp_rd(sel_m));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic [7:0] v1;
        logic [7:0] v2;
        void'($urandom(32'd1357));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        #22;
        rst_n = 1'b1;
        #40;
        chk("R1", "sda_oe after reset", sda_oe, 0);
        chk("R1", "power after reset", power, 0);
        do_receive();  // R1: slot 0 selected, holds 0
        do_read(4'h3); // R1: writable slot resets to 0

        // R2: foreign address ignored, following byte not acked
        bus_start();
        put_byte({7'h3A, 1'b0}, ack); chk("R2", "foreign addr nack", ack, 0);
        put_byte(8'h85, ack);         chk("R2", "silent after mismatch", ack, 0);
        bus_stop();
        do_receive(); // selection must still be the earlier one

        // R6: control keeps only two bits
        do_write(4'h0, 7'h7F);
        do_read(4'h0);
        chk("R6", "power bits", power, 2'b11);

        // R4: no auto-increment, last data byte wins
        do_write(4'h3, 7'h33);
        bus_start();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h82, ack);
        put_byte(8'h11, ack); chk("R4", "first data ack", ack, 1);
        put_byte(8'h22, ack); chk("R4", "second data ack", ack, 1);
        bus_stop();
        model[2] = 8'h22; sel_m = 4'h2;
        do_receive();
        do_read(4'h3);
        chk("R4", "neighbour slot kept", exp_rd(4'h3), 8'h33);

        // R3: command byte not stored
        do_write(4'h4, 7'h4C);
        do_send(4'h5);
        do_read(4'h4);

        // R7: reserved and channel slots
        do_write(4'h8, 7'h55);
        do_read(4'h8);
        do_write(4'hC, 7'h01);
        do_read(4'hC); do_read(4'hD); do_read(4'hE); do_read(4'hF);

        // R8: master ACK repeats the same slot
        do_write(4'h6, 7'h5A);
        bus_start();
        put_byte({DEV, 1'b1}, ack);
        get_byte(1'b1, v1);
        get_byte(1'b0, v2);
        bus_stop();
        chk("R8", "first read", v1, 8'h5A);
        chk("R8", "repeat read", v2, 8'h5A);

        // R9: repeated START mid-byte abandons it
        do_write(4'h5, 7'h2A);
        bus_start();
        put_byte({DEV, 1'b0}, ack);
        put_byte(8'h86, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte({DEV, 1'b1}, ack); chk("R9", "rematch ack", ack, 1);
        get_byte(1'b0, v1);
        bus_stop();
        sel_m = 4'h6;
        chk("R9", "partial byte not stored", v1, model[6]);

        // random mix
        for (int it = 0; it < 45; it++) begin
            int         op;
            logic [3:0] a;
            op = $urandom_range(0, 3);
            a  = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) begin
                ch0 = 16'($urandom);
                ch1 = 16'($urandom);
            end
            case (op)
                0: do_write(a, 7'($urandom_range(0, 127)));
                1: do_read(a);
                2: do_receive();
                default: do_send(a);
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule